// File: doc/BRIEF.md
# Flash Lock-Bit Command Controller

This block is the command front end of a flash-style memory model. Software issues bus write cycles that carry command bytes. Most operations take two write cycles: a setup byte, then a confirm byte or a data byte. The block supports five operations: clearing every block lock at once, locking one block, locking the whole device through a master lock, erasing a block, and programming a block. It keeps a lock state for every block and one for the master lock. Before it starts an operation it checks the supply-valid flag and the write protection.

The high-voltage override level and the supply-valid level reach the block as plain digital flags. A separate flag stands for the reset pin being pulled low. An accepted operation runs a busy phase of fixed length, and the ready output is low for all of that phase. The lock or array state changes only on the last cycle of the busy phase. If the reset flag is asserted while the block is busy, the operation is abandoned. The affected locks are then marked with a distinct "unknown" code, which the protection checks treat as locked.

Reads return the status byte whenever the block is not in array-read mode. In array-read mode they return the model byte of the addressed block.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After reset, `ready` is 1, the block is in array-read mode, every block lock and the master lock read 2'b00 (open), every array byte reads 0xFF and no error bit is set.
- R2: Clear-all-locks is the byte 0x60 followed by 0xD0. When the busy phase ends, every block lock field of `lock_state` reads 2'b00 at the same time.
- R3: Set-block-lock is the byte 0x60 followed by 0x01. The block is the one on `wr_addr` during the 0x01 cycle. When the busy phase ends, that block's field reads 2'b01 (set).
- R4: After a 0x60 or 0x20 setup, a following byte that is not a valid confirm sets status bits 5 and 4. No lock or array byte changes, and no busy phase starts.
- R5: If `vpp_ok` is low on a confirm cycle, status bit 3 is set. Bit 5 is also set for lock and erase operations, and bit 4 for program. Nothing changes and no busy phase starts.
- R6: Clear-all and set-block are refused when the master lock is not open and `rp_hv` is 0. A refusal sets status bits 1 and 5. With `rp_hv` at 1, the same operation proceeds.
- R7: Set-master is the byte 0x60 followed by 0xF1. It proceeds only with `rp_hv` at 1; otherwise it sets status bits 1 and 5. Once the master lock is not open, it never returns to open.
- R8: Erase is 0x20 followed by 0xD0, and it sets the block's byte to 0xFF. Program is 0x40 followed by a data byte, and it ANDs that byte into the block's byte. Both are refused on a block whose lock is not open while `rp_hv` is 0. A refused erase sets status bits 1 and 5; a refused program sets bits 1 and 4.
- R9: After an accepted confirm edge, `ready` is low for exactly BUSY_CYCLES clock cycles. Writes during that time are ignored, and status bit 7 equals `ready`.
- R10: The status byte is {ready, 0, e5, e4, e3, 0, e1, 0}. Any read outside array-read mode returns it. 0x70 selects status mode, 0xFF selects array-read mode, and every command sequence leaves the block in status mode.
- R11: Error bits 5, 4, 3 and 1 stay set through any command except 0x50, which clears all four.
- R12: Asserting `rp_low` during a busy phase ends it on the next edge with `ready` at 1 and array-read mode selected. The locks that the operation would have changed then read 2'b10 (unknown), and a master lock that was already set stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | BLK_W | Block index carried by the write |
| wr_data | input | 8 | Command or program data byte |
| rd_addr | input | BLK_W | Block index for array reads |
| rd_data | output | 8 | Status byte, or array byte in array-read mode |
| rp_low | input | 1 | Reset pin pulled low; aborts a busy phase |
| rp_hv | input | 1 | Reset pin at the high-voltage override level |
| vpp_ok | input | 1 | Programming supply inside its valid range |
| ready | output | 1 | 1 when idle, 0 during a busy phase |
| lock_state | output | 2*NUM_BLOCKS | Per-block lock code, block n at bits [2n+1:2n] |
| master_state | output | 2 | Master lock code |

## Verification
The hardest case to reach is the abort. The reset flag has to rise while a busy phase is partway through, and the block has to be able to tell that case apart from a normal finish. The bench first sets the master lock with the override level raised. It then starts clear-all, waits two cycles into the busy phase and pulses `rp_low` for one cycle. Every block then has to read the unknown code while the master lock still reads set. Ignored writes during the busy phase are reached by the same kind of timing: a setup byte is driven in the second busy cycle, and a later confirm byte must then leave the lock unchanged.

// File: rtl/flk_pkg.sv
package flk_pkg;

    localparam logic [7:0] CMD_LOCK_SETUP  = 8'h60;
    localparam logic [7:0] CMD_CLEAR_CONF  = 8'hD0;
    localparam logic [7:0] CMD_BLOCK_CONF  = 8'h01;
    localparam logic [7:0] CMD_MASTER_CONF = 8'hF1;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
    localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
    localparam logic [7:0] CMD_RD_STATUS   = 8'h70;
    localparam logic [7:0] CMD_RD_ARRAY    = 8'hFF;

    // error vector bit indices (status bits 5, 4, 3, 1)
    localparam int ERR_OP   = 3;
    localparam int ERR_SEQ  = 2;
    localparam int ERR_VPP  = 1;
    localparam int ERR_PROT = 0;

    typedef logic [3:0] err_t;

    typedef enum logic [1:0] {
        LK_OPEN = 2'b00,
        LK_SET  = 2'b01,
        LK_UNK  = 2'b10
    } lock_e;

    typedef enum logic [2:0] {
        M_ARRAY,
        M_STATUS,
        M_LOCK_SU,
        M_ERASE_SU,
        M_PROG_SU
    } mode_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CLR_ALL,
        OP_SET_BLK,
        OP_SET_MST,
        OP_ERASE,
        OP_PROG
    } op_e;

    typedef struct packed {
        mode_e nxt_mode;
        op_e   op;
        err_t  set_err;
        logic  clr_err;
    } dec_t;

    function automatic logic [7:0] status_byte(input logic rdy, input err_t e);
        return {rdy, 1'b0, e[ERR_OP], e[ERR_SEQ], e[ERR_VPP], 1'b0, e[ERR_PROT], 1'b0};
    endfunction

endpackage

// File: rtl/flk_cmd_decode.sv
module flk_cmd_decode
    import flk_pkg::*;
(
    input  mode_e      mode,
    input  logic       accept,
    input  logic [7:0] cmd,
    input  lock_e      blk_lock,
    input  lock_e      mst_lock,
    input  logic       rp_hv,
    input  logic       vpp_ok,
    output dec_t       dec
);

    op_e  cand;
    logic seq_err;
    logic denied;

    always_comb begin
        dec.nxt_mode = mode;
        dec.op       = OP_NONE;
        dec.set_err  = '0;
        dec.clr_err  = 1'b0;
        cand         = OP_NONE;
        seq_err      = 1'b0;
        denied       = 1'b0;

        if (accept) begin
            unique case (mode)
                M_LOCK_SU: begin
                    dec.nxt_mode = M_STATUS;
                    unique case (cmd)
                        CMD_CLEAR_CONF:  cand = OP_CLR_ALL;
                        CMD_BLOCK_CONF:  cand = OP_SET_BLK;
                        CMD_MASTER_CONF: cand = OP_SET_MST;
                        default:         seq_err = 1'b1;
                    endcase
                end
                M_ERASE_SU: begin
                    dec.nxt_mode = M_STATUS;
                    if (cmd == CMD_CLEAR_CONF) cand = OP_ERASE;
                    else                       seq_err = 1'b1;
                end
                M_PROG_SU: begin
                    dec.nxt_mode = M_STATUS;
                    cand = OP_PROG;
                end
                default: begin
                    unique case (cmd)
                        CMD_LOCK_SETUP:  dec.nxt_mode = M_LOCK_SU;
                        CMD_ERASE_SETUP: dec.nxt_mode = M_ERASE_SU;
                        CMD_PROG_SETUP:  dec.nxt_mode = M_PROG_SU;
                        CMD_RD_STATUS:   dec.nxt_mode = M_STATUS;
                        CMD_RD_ARRAY:    dec.nxt_mode = M_ARRAY;
                        CMD_CLR_STATUS:  dec.clr_err  = 1'b1;
                        default:         dec.nxt_mode = mode;
                    endcase
                end
            endcase
        end

        unique case (cand)
            OP_CLR_ALL, OP_SET_BLK: denied = (mst_lock != LK_OPEN) && !rp_hv;
            OP_SET_MST:             denied = !rp_hv;
            OP_ERASE, OP_PROG:      denied = (blk_lock != LK_OPEN) && !rp_hv;
            default:                denied = 1'b0;
        endcase

        if (cand != OP_NONE) begin
            if (!vpp_ok) begin
                dec.set_err[ERR_VPP] = 1'b1;
                if (cand == OP_PROG) dec.set_err[ERR_SEQ] = 1'b1;
                else                 dec.set_err[ERR_OP]  = 1'b1;
            end else if (denied) begin
                dec.set_err[ERR_PROT] = 1'b1;
                if (cand == OP_PROG) dec.set_err[ERR_SEQ] = 1'b1;
                else                 dec.set_err[ERR_OP]  = 1'b1;
            end else begin
                dec.op = cand;
            end
        end

        if (seq_err) begin
            dec.set_err[ERR_SEQ] = 1'b1;
            dec.set_err[ERR_OP]  = 1'b1;
        end
    end

endmodule

// File: rtl/flk_lock_store.sv
module flk_lock_store
    import flk_pkg::*;
#(
    parameter int NB    = 8,
    parameter int BLK_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic             abort,
    input  op_e              op,
    input  logic [BLK_W-1:0] blk,
    input  logic [BLK_W-1:0] sel_blk,
    output lock_e            sel_lock,
    output lock_e            mst_lock,
    output logic [2*NB-1:0]  lock_flat
);

    lock_e lk [NB];
    lock_e mst_q;

    for (genvar g = 0; g < NB; g++) begin : g_blk
        logic hit;
        assign hit = (blk == BLK_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                lk[g] <= LK_OPEN;
            end else if (commit && op == OP_CLR_ALL) begin
                lk[g] <= LK_OPEN;
            end else if (commit && op == OP_SET_BLK && hit) begin
                lk[g] <= LK_SET;
            end else if (abort && (op == OP_CLR_ALL || (op == OP_SET_BLK && hit))) begin
                lk[g] <= LK_UNK;
            end
        end

        assign lock_flat[2*g +: 2] = lk[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mst_q <= LK_OPEN;
        end else if (commit && op == OP_SET_MST) begin
            mst_q <= LK_SET;
        end else if (abort && op == OP_SET_MST && mst_q == LK_OPEN) begin
            mst_q <= LK_UNK;
        end
    end

    assign sel_lock = lk[sel_blk];
    assign mst_lock = mst_q;

endmodule

// File: rtl/flk_data_store.sv
module flk_data_store
    import flk_pkg::*;
#(
    parameter int NB    = 8,
    parameter int BLK_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  op_e              op,
    input  logic [BLK_W-1:0] blk,
    input  logic [7:0]       pdata,
    input  logic [BLK_W-1:0] rd_addr,
    output logic [7:0]       rd_byte
);

    logic [7:0] mem [NB];

    for (genvar g = 0; g < NB; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= 8'hFF;
            end else if (commit && blk == BLK_W'(g)) begin
                if (op == OP_ERASE)     mem[g] <= 8'hFF;
                else if (op == OP_PROG) mem[g] <= mem[g] & pdata;
            end
        end
    end

    assign rd_byte = mem[rd_addr];

endmodule

// File: rtl/flk_busy_timer.sv
module flk_busy_timer #(
    parameter int CYCLES = 6,
    parameter int CW     = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || abort)  cnt <= '0;
        else if (start)    cnt <= CW'(CYCLES);
        else if (cnt != 0) cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != 0);
    assign done = (cnt == CW'(1)) && !abort;

endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
    import flk_pkg::*;
#(
    parameter int NUM_BLOCKS  = 8,
    parameter int BUSY_CYCLES = 6,
    parameter int BLK_W       = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [BLK_W-1:0]        wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [BLK_W-1:0]        rd_addr,
    output logic [7:0]              rd_data,
    input  logic                    rp_low,
    input  logic                    rp_hv,
    input  logic                    vpp_ok,
    output logic                    ready,
    output logic [2*NUM_BLOCKS-1:0] lock_state,
    output logic [1:0]              master_state
);

    mode_e            mode_q;
    err_t             err_q;
    op_e              op_q;
    logic [BLK_W-1:0] blk_q;
    logic [7:0]       pdat_q;

    logic  busy, done, accept, abort;
    lock_e sel_lock, mst_lock;
    dec_t  dec;
    logic [7:0] arr_byte;

    assign accept = wr_en && !busy && !rp_low;
    assign abort  = rp_low && busy;

    flk_cmd_decode u_dec (
        .mode     (mode_q),
        .accept   (accept),
        .cmd      (wr_data),
        .blk_lock (sel_lock),
        .mst_lock (mst_lock),
        .rp_hv    (rp_hv),
        .vpp_ok   (vpp_ok),
        .dec      (dec)
    );

    flk_busy_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (dec.op != OP_NONE),
        .abort (abort),
        .busy  (busy),
        .done  (done)
    );

    flk_lock_store #(.NB(NUM_BLOCKS), .BLK_W(BLK_W)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .commit    (done),
        .abort     (abort),
        .op        (op_q),
        .blk       (blk_q),
        .sel_blk   (wr_addr),
        .sel_lock  (sel_lock),
        .mst_lock  (mst_lock),
        .lock_flat (lock_state)
    );

    flk_data_store #(.NB(NUM_BLOCKS), .BLK_W(BLK_W)) u_data (
        .clk     (clk),
        .rst     (rst),
        .commit  (done),
        .op      (op_q),
        .blk     (blk_q),
        .pdata   (pdat_q),
        .rd_addr (rd_addr),
        .rd_byte (arr_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_ARRAY;
            err_q  <= '0;
            op_q   <= OP_NONE;
            blk_q  <= '0;
            pdat_q <= '0;
        end else if (rp_low) begin
            mode_q <= M_ARRAY;
        end else begin
            mode_q <= dec.nxt_mode;
            if (dec.clr_err) err_q <= '0;
            else             err_q <= err_q | dec.set_err;
            if (dec.op != OP_NONE) begin
                op_q   <= dec.op;
                blk_q  <= wr_addr;
                pdat_q <= wr_data;
            end
        end
    end

    assign ready        = !busy;
    assign master_state = mst_lock;
    assign rd_data      = (mode_q == M_ARRAY) ? arr_byte : status_byte(!busy, err_q);

endmodule

// File: rtl/flk_checker.sv
module flk_checker
    import flk_pkg::*;
#(
    parameter int NB = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [7:0]    wr_data,
    input logic          rp_low,
    input logic          ready,
    input logic [7:0]    rd_data,
    input logic [2*NB-1:0] lock_state,
    input logic [1:0]    master_state,
    input err_t          err_q,
    input mode_e         mode_q
);

    logic clr_cmd;
    assign clr_cmd = wr_en && ready && !rp_low && wr_data == CMD_CLR_STATUS &&
                     (mode_q == M_ARRAY || mode_q == M_STATUS);

    p_status_ready_r9: assert property (@(posedge clk) disable iff (rst)
        mode_q != M_ARRAY |-> rd_data[7] == ready);

    p_master_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        master_state != 2'b00 |=> master_state != 2'b00);

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!ready && !rp_low) |=> (ready || $stable(lock_state)));

    p_abort_ready_r12: assert property (@(posedge clk) disable iff (rst)
        rp_low |=> ready);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (err_q != '0 && !clr_cmd) |=> ((err_q & $past(err_q)) == $past(err_q)));

endmodule

bind flash_lock_ctrl flk_checker #(.NB(NUM_BLOCKS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rp_low       (rp_low),
    .ready        (ready),
    .rd_data      (rd_data),
    .lock_state   (lock_state),
    .master_state (master_state),
    .err_q        (err_q),
    .mode_q       (mode_q)
);

// File: tb/tb_flash_lock_ctrl.sv
module tb_flash_lock_ctrl;

    localparam int NB    = 8;
    localparam int BUSY  = 6;
    localparam int BW    = 3;
    localparam int NROWS = 29;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [BW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [BW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          rp_low = 1'b0;
    logic          rp_hv = 1'b0;
    logic          vpp_ok = 1'b1;
    logic          ready;
    logic [2*NB-1:0] lock_state;
    logic [1:0]    master_state;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    flash_lock_ctrl #(.NUM_BLOCKS(NB), .BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rp_low(rp_low), .rp_hv(rp_hv),
        .vpp_ok(vpp_ok), .ready(ready), .lock_state(lock_state),
        .master_state(master_state)
    );

    // {data, addr, vpp_ok, rp_hv, expected rd_data}
    localparam logic [20:0] VEC [NROWS] = '{
        {8'h60, 3'd2, 1'b1, 1'b0, 8'h80},
        {8'h01, 3'd2, 1'b1, 1'b0, 8'h80},
        {8'hFF, 3'd2, 1'b1, 1'b0, 8'hFF},
        {8'h20, 3'd2, 1'b1, 1'b0, 8'h80},
        {8'hD0, 3'd2, 1'b1, 1'b0, 8'hA2},
        {8'h50, 3'd2, 1'b1, 1'b0, 8'h80},
        {8'h40, 3'd3, 1'b1, 1'b0, 8'h80},
        {8'h0F, 3'd3, 1'b1, 1'b0, 8'h80},
        {8'hFF, 3'd3, 1'b1, 1'b0, 8'h0F},
        {8'h60, 3'd0, 1'b1, 1'b0, 8'h80},
        {8'h77, 3'd0, 1'b1, 1'b0, 8'hB0},
        {8'h50, 3'd0, 1'b1, 1'b0, 8'h80},
        {8'h40, 3'd3, 1'b0, 1'b0, 8'h80},
        {8'h00, 3'd3, 1'b0, 1'b0, 8'h98},
        {8'h50, 3'd3, 1'b1, 1'b0, 8'h80},
        {8'hFF, 3'd3, 1'b1, 1'b0, 8'h0F},
        {8'h60, 3'd0, 1'b1, 1'b0, 8'h80},
        {8'hF1, 3'd0, 1'b1, 1'b0, 8'hA2},
        {8'h50, 3'd0, 1'b1, 1'b0, 8'h80},
        {8'h60, 3'd0, 1'b1, 1'b1, 8'h80},
        {8'hF1, 3'd0, 1'b1, 1'b1, 8'h80},
        {8'h60, 3'd0, 1'b1, 1'b0, 8'h80},
        {8'hD0, 3'd0, 1'b1, 1'b0, 8'hA2},
        {8'h50, 3'd0, 1'b1, 1'b0, 8'h80},
        {8'h60, 3'd0, 1'b1, 1'b1, 8'h80},
        {8'hD0, 3'd0, 1'b1, 1'b1, 8'h80},
        {8'h20, 3'd2, 1'b1, 1'b0, 8'h80},
        {8'hD0, 3'd2, 1'b1, 1'b0, 8'h80},
        {8'hFF, 3'd2, 1'b1, 1'b0, 8'hFF}
    };

    function automatic string row_req(input int i);
        if (i < 3)       return "R3";
        else if (i < 9)  return "R8";
        else if (i < 12) return "R4";
        else if (i < 16) return "R5";
        else if (i < 21) return "R7";
        else if (i < 26) return "R6";
        else             return "R2";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d, input logic [BW-1:0] a);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_addr = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 ready", ready, 1);
        check("R1 locks", lock_state, 0);
        check("R1 master", master_state, 0);
        check("R1 array byte", rd_data, 8'hFF);

        for (int i = 0; i < NROWS; i++) begin
            vpp_ok  = VEC[i][9];
            rp_hv   = VEC[i][8];
            rd_addr = VEC[i][12:10];
            put(VEC[i][20:13], VEC[i][12:10]);
            wait_ready();
            check(row_req(i), rd_data, VEC[i][7:0]);
        end
        vpp_ok = 1'b1; rp_hv = 1'b0;

        check("R2 all locks open", lock_state, 0);
        check("R7 master set", master_state, 2'b01);

        // R9 busy length and write ignored during busy
        rp_hv = 1'b1;
        put(8'h60, 3'd5);
        put(8'h01, 3'd5);
        cnt = 0;
        while (!ready) begin
            cnt++;
            if (cnt == 2) begin wr_en = 1'b1; wr_data = 8'h60; end
            else wr_en = 1'b0;
            @(negedge clk);
        end
        wr_en = 1'b0;
        check("R9 busy cycles", cnt, BUSY);
        check("R3 block5 set", lock_state[11:10], 2'b01);
        check("R9 status after", rd_data, 8'h80);
        rp_hv = 1'b1;
        put(8'hD0, 3'd5);
        wait_ready();
        check("R9 ignored write", lock_state[11:10], 2'b01);
        rp_hv = 1'b0;

        // R10 mode switching
        rd_addr = 3'd3;
        put(8'hFF, 3'd0);
        check("R10 array read", rd_data, 8'h0F);
        put(8'h70, 3'd0);
        check("R10 status read", rd_data, 8'h80);

        // R11 sticky error bits
        put(8'h60, 3'd0);
        put(8'h55, 3'd0);
        check("R4 bad confirm", rd_data, 8'hB0);
        put(8'hFF, 3'd0);
        put(8'h70, 3'd0);
        check("R11 sticky", rd_data, 8'hB0);
        put(8'h50, 3'd0);
        check("R11 cleared", rd_data, 8'h80);

        // R12 abort during busy
        rp_hv = 1'b1;
        put(8'h60, 3'd0);
        put(8'hD0, 3'd0);
        check("R12 busy started", ready, 0);
        @(negedge clk);
        rp_low = 1'b1;
        @(negedge clk);
        rp_low = 1'b0;
        check("R12 ready", ready, 1);
        check("R12 locks unknown", lock_state, 16'hAAAA);
        check("R12 master kept", master_state, 2'b01);
        check("R12 array mode", rd_data, 8'h0F);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule